// File: doc/BRIEF.md
# Debug Command Acknowledge Pulse Generator

This block sits in the serial debug clock domain of a single-wire, open-drain debug port. It tells an external host that a command it sent has finished. The serial receiver pulses a strobe in the 16th debug clock cycle of the command's final bit. With that strobe come two flags: whether the command must be executed by the CPU, and whether it is a read. CPU-executed commands finish when the core clock domain pulses a completion strobe. That event is carried into the debug domain as a level toggle, passed through a two-flop synchronizer and then edge-detected.

After the command ends, the block waits at least 32 debug clock cycles and, if needed, for CPU completion. There is no upper limit on that wait. It then drives the pin low for 16 cycles and drives it high for one cycle to speed up the rising edge. After that it releases the pin. When the pin is released, a read command gets a one-cycle strobe that starts its data phase. Every command also finds the block idle again, ready to accept the next command.

Top module: `dbg_ack_pulse`

## Requirements
- R1: After a synchronous active-high reset, `pin_oe`, `pin_out` and `data_go` are 0 and `idle` is 1. A reset taken while a command waits for completion drops that command with no pulse.
- R2: Once the acknowledge starts, the pin is driven low (`pin_oe`=1, `pin_out`=0) for exactly 16 consecutive debug clock cycles.
- R3: The low drive is followed by exactly one cycle of high drive (`pin_oe`=1, `pin_out`=1), and then the pin is released (`pin_oe`=0). `pin_out` is never 1 while `pin_oe` is 0.
- R4: The low drive never begins earlier than 32 cycles after the clock edge that samples `cmd_end`. For a command with `cmd_cpu`=0, it begins exactly in that 32nd cycle.
- R5: A CPU completion that arrives before the 32-cycle minimum has elapsed is remembered, and the low drive then begins exactly in the 32nd cycle.
- R6: A CPU-executed command waits without limit for completion. After a late completion, the low drive begins between 1 and 6 debug cycles after the completion strobe.
- R7: A completion strobe that arrives while no command is pending has no effect. No pulse follows it, and it does not satisfy the next command's wait.
- R8: A `cmd_end` strobe that arrives while an acknowledge is in progress is ignored and produces no second pulse.
- R9: In the cycle the pin is released, `idle` is 1. In that same cycle `data_go` is 1 for exactly one cycle if the command had `cmd_rd`=1, and stays 0 for write and control commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbg_clk | input | 1 | Serial debug clock |
| cpu_clk | input | 1 | Core clock, may be asynchronous to dbg_clk |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| cmd_end | input | 1 | One-cycle strobe in the 16th cycle of the command's last bit |
| cmd_cpu | input | 1 | Command needs CPU execution (valid with cmd_end) |
| cmd_rd | input | 1 | Command is a read with a data phase (valid with cmd_end) |
| cpu_done | input | 1 | Completion strobe, one cpu_clk cycle, core domain |
| pin_oe | output | 1 | Debug pin output enable |
| pin_out | output | 1 | Debug pin driven value when enabled |
| idle | output | 1 | Block is idle and will accept a new command |
| data_go | output | 1 | One-cycle strobe starting the data-read phase |

## Verification
The assertions assume that `cmd_end` is a single-cycle strobe and that `rst` is held long enough to be sampled by both clocks. They also assume that `cpu_done` lasts one core cycle, with consecutive completions spaced far enough apart for the toggle to pass the synchronizer. The stimulus keeps to these assumptions. It drives every input on the falling edge of its own clock and holds reset for several debug cycles. It fires each completion once per command, or once while idle, and always leaves dozens of debug cycles between completions. Because the two clocks are unrelated, the bench judges late completions against a latency window rather than an exact cycle.

// File: rtl/dbg_ack_pulse.sv
module dbg_ack_pulse #(
  parameter int MIN_WAIT   = 32,
  parameter int LOW_CYCLES = 16
) (
  input  logic dbg_clk,
  input  logic cpu_clk,
  input  logic rst,
  input  logic cmd_end,
  input  logic cmd_cpu,
  input  logic cmd_rd,
  input  logic cpu_done,
  output logic pin_oe,
  output logic pin_out,
  output logic idle,
  output logic data_go
);

  localparam int CW = $clog2((MIN_WAIT > LOW_CYCLES) ? MIN_WAIT : LOW_CYCLES) + 1;
  localparam logic [CW-1:0] WAIT_LAST = CW'(MIN_WAIT - 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LOW, S_SPD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          got, rd;
  logic          tgl;
  logic [2:0]    sync;
  logic          done_evt;

  always_ff @(posedge cpu_clk) begin
    if (rst)           tgl <= 1'b0;
    else if (cpu_done) tgl <= ~tgl;
  end

  always_ff @(posedge dbg_clk) begin
    if (rst) sync <= '0;
    else     sync <= {sync[1:0], tgl};
  end

  assign done_evt = sync[2] ^ sync[1];

  always_ff @(posedge dbg_clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      got     <= 1'b0;
      rd      <= 1'b0;
      data_go <= 1'b0;
    end else begin
      data_go <= 1'b0;
      case (st)
        S_IDLE: if (cmd_end) begin
          st  <= S_WAIT;
          cnt <= '0;
          got <= ~cmd_cpu;
          rd  <= cmd_rd;
        end
        S_WAIT: begin
          if (done_evt) got <= 1'b1;
          if (cnt != WAIT_LAST) cnt <= cnt + 1'b1;
          else if (got || done_evt) begin
            st  <= S_LOW;
            cnt <= '0;
          end
        end
        S_LOW: begin
          if (cnt == LOW_LAST) st <= S_SPD;
          else                 cnt <= cnt + 1'b1;
        end
        default: begin
          st      <= S_IDLE;
          data_go <= rd;
        end
      endcase
    end
  end

  assign pin_oe  = (st == S_LOW) || (st == S_SPD);
  assign pin_out = (st == S_SPD);
  assign idle    = (st == S_IDLE);

endmodule

// File: rtl/dbg_ack_pulse_chk.sv
module dbg_ack_pulse_chk #(
  parameter int MIN_WAIT   = 32,
  parameter int LOW_CYCLES = 16
) (
  input logic dbg_clk,
  input logic rst,
  input logic cmd_end,
  input logic cmd_cpu,
  input logic pin_oe,
  input logic pin_out,
  input logic idle,
  input logic data_go
);

  localparam int SW = $clog2(MIN_WAIT) + 2;
  localparam int RW = $clog2(LOW_CYCLES) + 2;

  logic [SW-1:0] since;
  logic [RW-1:0] run;
  logic          nocpu, low_q, low;

  assign low = pin_oe && !pin_out;

  always_ff @(posedge dbg_clk) begin
    if (rst) begin
      since <= '1;
      run   <= '0;
      nocpu <= 1'b0;
      low_q <= 1'b0;
    end else begin
      low_q <= low;
      if (cmd_end && idle) begin
        since <= '0;
        nocpu <= !cmd_cpu;
      end else if (since != '1) since <= since + 1'b1;
      if (low) begin
        if (run != '1) run <= run + 1'b1;
      end else run <= '0;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge dbg_clk) disable iff (rst) idle |-> !pin_oe); // R1
  AST_LOW_LENGTH: assert property (@(posedge dbg_clk) disable iff (rst) (low_q && !low) |-> (run == RW'(LOW_CYCLES) && pin_out)); // R2
  AST_OUT_NEEDS_OE: assert property (@(posedge dbg_clk) disable iff (rst) pin_out |-> pin_oe); // R3
  AST_SPEEDUP_ONE: assert property (@(posedge dbg_clk) disable iff (rst) pin_out |=> !pin_oe); // R3
  AST_MIN_WAIT: assert property (@(posedge dbg_clk) disable iff (rst) $rose(low) |-> (since >= SW'(MIN_WAIT))); // R4
  AST_NOCPU_EXACT: assert property (@(posedge dbg_clk) disable iff (rst) ($rose(low) && nocpu) |-> (since == SW'(MIN_WAIT))); // R4
  AST_DATA_AFTER_SPD: assert property (@(posedge dbg_clk) disable iff (rst) data_go |-> ($past(pin_out) && !pin_oe && idle)); // R9

endmodule

bind dbg_ack_pulse dbg_ack_pulse_chk #(.MIN_WAIT(MIN_WAIT), .LOW_CYCLES(LOW_CYCLES)) chk_i (
  .dbg_clk(dbg_clk), .rst(rst), .cmd_end(cmd_end), .cmd_cpu(cmd_cpu),
  .pin_oe(pin_oe), .pin_out(pin_out), .idle(idle), .data_go(data_go)
);

// File: tb/dbg_ack_pulse_tb_top.sv
`timescale 1ns/100ps
module dbg_ack_pulse_tb_top;

  logic dbg_clk = 0, cpu_clk = 0, rst = 1;
  logic cmd_end = 0, cmd_cpu = 0, cmd_rd = 0, cpu_done = 0;
  logic pin_oe, pin_out, idle, data_go;

  always #10 dbg_clk = ~dbg_clk;
  always #7.3 cpu_clk = ~cpu_clk;

  dbg_ack_pulse dut_i (
    .dbg_clk(dbg_clk), .cpu_clk(cpu_clk), .rst(rst), .cmd_end(cmd_end),
    .cmd_cpu(cmd_cpu), .cmd_rd(cmd_rd), .cpu_done(cpu_done),
    .pin_oe(pin_oe), .pin_out(pin_out), .idle(idle), .data_go(data_go)
  );

  int cyc = 0;
  always @(posedge dbg_clk) cyc <= cyc + 1;

  typedef struct {int strobe; int done; bit cpu; bit rd; bit early;} item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic fire_done(output int at);
    @(negedge cpu_clk);
    cpu_done = 1;
    at = cyc;
    @(negedge cpu_clk);
    cpu_done = 0;
  endtask

  task automatic wait_idle();
    wait (exp_q.size() == 0);
    do @(negedge dbg_clk); while (!idle);
    repeat (3) @(negedge dbg_clk);
  endtask

  task automatic issue(input bit cpu, input bit rd, input int gap);
    item_t it;
    @(negedge dbg_clk);
    cmd_end = 1; cmd_cpu = cpu; cmd_rd = rd;
    it.strobe = cyc + 1; it.cpu = cpu; it.rd = rd; it.done = -1; it.early = 0;
    @(negedge dbg_clk);
    cmd_end = 0; cmd_cpu = 0; cmd_rd = 0;
    if (cpu) begin
      repeat (gap) @(negedge dbg_clk);
      fire_done(it.done);
      it.early = (gap < 15);
    end
    exp_q.push_back(it);
  endtask

  initial begin
    item_t it;
    int st, len;
    forever begin
      @(negedge dbg_clk);
      if (!rst && pin_oe && !pin_out) begin
        st = cyc; len = 0;
        it.rd = 0;
        if (exp_q.size() == 0) chk(0, "R8", "unexpected acknowledge at cycle", st, -1);
        else begin
          it = exp_q.pop_front();
          if (!it.cpu) chk(st == it.strobe + 32, "R4", "start cycle, no CPU", st, it.strobe + 32);
          else if (it.early) chk(st == it.strobe + 32, "R5", "start cycle, early completion", st, it.strobe + 32);
          else begin
            chk(st >= it.strobe + 32, "R4", "start not before minimum", st, it.strobe + 32);
            chk(st > it.done && st <= it.done + 6, "R6", "start after late completion", st, it.done + 1);
          end
        end
        while (pin_oe && !pin_out) begin len++; @(negedge dbg_clk); end
        chk(len == 16, "R2", "low length", len, 16);
        chk(pin_oe && pin_out, "R3", "speedup drive oe&out", {pin_oe, pin_out}, 3);
        @(negedge dbg_clk);
        chk(!pin_oe, "R3", "released after one speedup cycle", pin_oe, 0);
        chk(data_go == it.rd, "R9", "data_go at release", data_go, it.rd);
        chk(idle, "R9", "idle at release", idle, 1);
        @(negedge dbg_clk);
        chk(!data_go, "R9", "data_go one cycle", data_go, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge dbg_clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    bit seen;
    repeat (5) @(negedge dbg_clk);
    rst = 0;
    @(negedge dbg_clk);
    chk(!pin_oe && !pin_out && !data_go && idle, "R1", "reset state {oe,out,go,idle}",
        {pin_oe, pin_out, data_go, idle}, 1);

    issue(0, 0, 0); wait_idle();
    issue(0, 1, 0); wait_idle();
    issue(1, 1, 5); wait_idle();
    issue(1, 0, 60); wait_idle();
    issue(1, 1, 200); wait_idle();

    // R7: stray completion while idle
    fire_done(d);
    seen = 0;
    repeat (60) begin @(negedge dbg_clk); if (pin_oe) seen = 1; end
    chk(!seen, "R7", "pin driven after stray completion", seen, 0);
    issue(1, 0, 80); wait_idle();

    // R8: strobe during active acknowledge
    issue(0, 1, 0);
    do @(negedge dbg_clk); while (!pin_oe);
    repeat (4) @(negedge dbg_clk);
    cmd_end = 1; cmd_cpu = 0;
    @(negedge dbg_clk);
    cmd_end = 0;
    wait_idle();
    seen = 0;
    repeat (60) begin @(negedge dbg_clk); if (pin_oe) seen = 1; end
    chk(!seen, "R8", "second pulse after ignored strobe", seen, 0);

    // R1: reset while waiting for completion
    @(negedge dbg_clk);
    cmd_end = 1; cmd_cpu = 1;
    @(negedge dbg_clk);
    cmd_end = 0; cmd_cpu = 0;
    repeat (40) @(negedge dbg_clk);
    rst = 1;
    repeat (4) @(negedge dbg_clk);
    rst = 0;
    @(negedge dbg_clk);
    chk(!pin_oe && idle, "R1", "mid-wait reset {oe,idle}", {pin_oe, idle}, 1);
    fire_done(d);
    seen = 0;
    repeat (60) begin @(negedge dbg_clk); if (pin_oe) seen = 1; end
    chk(!seen, "R1", "pulse after reset-dropped command", seen, 0);

    issue(0, 1, 0); wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule